// File: doc/BRIEF.md
# Colour Subcarrier Phase Oscillator

This block is the numerically controlled oscillator that supplies colour subcarrier phase to a standard-definition composite video encoder. It holds a phase accumulator that moves forward once for every pixel-clock tick. The step size is a 32-bit frequency word. It uses a scaled convention: a word of 0x80000000 advances the phase by exactly one full turn per pixel. The output is the top bits of the accumulator, registered, and it feeds a sine/cosine table outside this block.

The frequency word comes from one of three places. When no override is active, each of the four colour standards has a built-in word. When the custom enable is set, a programmed word is used instead. In SECAM operation the block alternates line by line between two programmed words: the red-difference centre word on even lines and the blue-difference centre word on odd lines. Both words are written 16 bits at a time through a small write port.

At every line-start pulse the accumulator is loaded with an 8-bit start phase. Each step of that value is 360/256 degrees. Also at each line start, a line-parity flag toggles. PAL-family standards use this flag to invert the V axis. A pixel counter that restarts at each line produces the colour-burst window flag. A synchronous soft reset clears the running state and restores every frequency word to its default.

Top module: `subcarrier_nco`

## Requirements
- R1: While the asynchronous active-low reset is applied, `phase_o`, `burst_o` and `v_invert_o` are all 0.
- R2: In a cycle with `pix_tick` high and no line start, the accumulator advances by the effective frequency word modulo 2^31. A full turn is 2^31, so word 0x80000000 leaves the phase unchanged and word 0x40000000 advances it by half a turn. `phase_o` is accumulator bits [30:21], registered, and appears one cycle after the accumulator changes.
- R3: In a cycle with neither `pix_tick`, `line_start` nor `soft_rst` high, the accumulator holds its value.
- R4: A `line_start` pulse loads the accumulator with `phase_ofs` in bits [30:23] and zeros below it. This happens even when `pix_tick` is high in the same cycle. As a result, `phase_o` equals `{phase_ofs, 2'b00}` two cycles later.
- R5: With `custom_en` and `secam_en` low, the effective word depends on `std_sel`: 0 gives 0x21F07C1F, 1 gives 0x2A098ACB, 2 gives 0x21E6EFE3 and 3 gives 0x21F69446.
- R6: With `custom_en` high and `secam_en` low, the effective word is the programmed main word. A write with `wr_addr` 0 sets bits [31:16] and a write with `wr_addr` 1 sets bits [15:0]. Writes take effect from the next cycle.
- R7: With `secam_en` high, the effective word is the main word on even lines and the second word on odd lines, whatever the value of `custom_en`. The second word is written at `wr_addr` 2 (bits [31:16]) and 3 (bits [15:0]). Reset defaults are 0x29C71C72 for the main word and 0x284BDA13 for the second word.
- R8: Line parity starts at 0 and toggles at each `line_start`. `v_invert_o` equals the parity when `std_sel` is nonzero and `secam_en` is low, and is 0 otherwise.
- R9: `burst_o` is high while the count of pixel ticks since the last line start lies in [20, 56). The count restarts at 0 on `line_start` and saturates at 1023.
- R10: `soft_rst` takes priority over writes, line starts and ticks. It clears the accumulator, the parity and the pixel count, and restores both programmed words to their defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| pix_tick | input | 1 | Pixel-clock enable; advances the accumulator |
| line_start | input | 1 | Line start pulse; reseeds phase and toggles parity |
| wr_en | input | 1 | Frequency word half write strobe |
| wr_addr | input | 2 | Bit 1 selects word (0 main, 1 second), bit 0 selects half (0 upper, 1 lower) |
| wr_data | input | 16 | Half-word write data |
| std_sel | input | 2 | Colour standard: 0 NTSC, 1 PAL, 2 PAL-M, 3 PAL-N |
| custom_en | input | 1 | Use the programmed main word instead of the standard's default |
| secam_en | input | 1 | SECAM line-alternating word selection |
| phase_ofs | input | 8 | Start phase loaded at line start, 360/256 degrees per step |
| phase_o | output | 10 | Truncated subcarrier phase for the sine lookup |
| burst_o | output | 1 | Colour burst window flag |
| v_invert_o | output | 1 | V-axis inversion for alternate PAL lines |

## Verification
Two functions can fall in the same cycle: the per-pixel advance and the line-start reseed. Whenever both are requested, the reseed must win. The bench provokes this by holding `pix_tick` high through every line-start pulse in a sweep of all 256 start phases. It expects `phase_o` to show exactly the loaded offset two cycles later, with no word added. It also applies a soft reset in the same cycle as a write and a line start. It then judges from the following SECAM lines that the default words, rather than the written half, drive the phase.

// File: rtl/subcarrier_nco_pkg.sv
package subcarrier_nco_pkg;

   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      STD_NTSC  = 2'd0,
      STD_PAL   = 2'd1,
      STD_PAL_M = 2'd2,
      STD_PAL_N = 2'd3
   } tv_std_e;

   localparam logic [WORD_W-1:0] FCW_NTSC   = 32'h21F0_7C1F;
   localparam logic [WORD_W-1:0] FCW_PAL    = 32'h2A09_8ACB;
   localparam logic [WORD_W-1:0] FCW_PAL_M  = 32'h21E6_EFE3;
   localparam logic [WORD_W-1:0] FCW_PAL_N  = 32'h21F6_9446;
   localparam logic [WORD_W-1:0] FCW_MAIN_RST = 32'h29C7_1C72;
   localparam logic [WORD_W-1:0] FCW_ALT_RST  = 32'h284B_DA13;

   function automatic logic [WORD_W-1:0] std_fcw(tv_std_e s);
      case (s)
         STD_NTSC:  return FCW_NTSC;
         STD_PAL:   return FCW_PAL;
         STD_PAL_M: return FCW_PAL_M;
         default:   return FCW_PAL_N;
      endcase
   endfunction

endpackage

// File: rtl/nco_fcw_bank.sv
module nco_fcw_bank
   import subcarrier_nco_pkg::*;
#(
   parameter int HALF_W = 16,
   localparam int NH     = WORD_W / HALF_W,
   localparam int HIDX_W = (NH > 1) ? $clog2(NH) : 1,
   localparam int ADDR_W = HIDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [HALF_W-1:0] wr_data,
   input  tv_std_e           std_sel,
   input  logic              custom_en,
   input  logic              secam_en,
   input  logic              line_odd,
   output logic [WORD_W-1:0] fcw_o
);

   if ((WORD_W % HALF_W) != 0) begin : g_bad_half
      $error("HALF_W must divide the word width");
   end

   logic [WORD_W-1:0] main_q;
   logic [WORD_W-1:0] alt_q;

   for (genvar h = 0; h < NH; h++) begin : g_half
      localparam int LSB = WORD_W - (h + 1) * HALF_W;
      logic [HALF_W-1:0] main_r;
      logic [HALF_W-1:0] alt_r;
      logic              hit;

      assign hit = wr_en && (wr_addr[HIDX_W-1:0] == HIDX_W'(h));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            main_r <= FCW_MAIN_RST[LSB +: HALF_W];
            alt_r  <= FCW_ALT_RST[LSB +: HALF_W];
         end else if (soft_rst) begin
            main_r <= FCW_MAIN_RST[LSB +: HALF_W];
            alt_r  <= FCW_ALT_RST[LSB +: HALF_W];
         end else if (hit) begin
            if (wr_addr[ADDR_W-1]) alt_r  <= wr_data;
            else                   main_r <= wr_data;
         end
      end

      assign main_q[LSB +: HALF_W] = main_r;
      assign alt_q[LSB +: HALF_W]  = alt_r;
   end

   always_comb begin
      if (secam_en)       fcw_o = line_odd ? alt_q : main_q;
      else if (custom_en) fcw_o = main_q;
      else                fcw_o = std_fcw(std_sel);
   end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
   import subcarrier_nco_pkg::*;
#(
   parameter int PH_W  = 10,
   parameter int OFS_W = 8,
   localparam int ACC_W = WORD_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              line_start,
   input  logic              pix_tick,
   input  logic [OFS_W-1:0]  phase_ofs,
   input  logic [WORD_W-1:0] fcw,
   output logic [PH_W-1:0]   phase_o
);

   if (PH_W > ACC_W || OFS_W > ACC_W) begin : g_bad_width
      $error("phase or offset wider than the accumulator");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;

   assign acc_sum = ACC_W'({1'b0, acc_q} + fcw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          acc_q <= '0;
      else if (soft_rst)   acc_q <= '0;
      else if (line_start) acc_q <= {phase_ofs, {(ACC_W-OFS_W){1'b0}}};
      else if (pix_tick)   acc_q <= acc_sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_o <= '0;
      else        phase_o <= acc_q[ACC_W-1 -: PH_W];
   end

endmodule

// File: rtl/nco_line_timing.sv
module nco_line_timing #(
   parameter int CNT_W       = 10,
   parameter int BURST_START = 20,
   parameter int BURST_LEN   = 36,
   localparam int BURST_END  = BURST_START + BURST_LEN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic line_start,
   input  logic pix_tick,
   output logic line_odd_o,
   output logic burst_o
);

   if (BURST_START < 1 || BURST_END >= (1 << CNT_W)) begin : g_bad_window
      $error("burst window must start after line start and fit the counter");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         line_odd_o <= 1'b0;
      end else if (soft_rst) begin
         cnt_q      <= '0;
         line_odd_o <= 1'b0;
      end else if (line_start) begin
         cnt_q      <= '0;
         line_odd_o <= ~line_odd_o;
      end else if (pix_tick && (cnt_q != '1)) begin
         cnt_q      <= cnt_q + 1'b1;
      end
   end

   assign burst_o = (cnt_q >= CNT_W'(BURST_START)) && (cnt_q < CNT_W'(BURST_END));

endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
   import subcarrier_nco_pkg::*;
#(
   parameter int HALF_W      = 16,
   parameter int PH_W        = 10,
   parameter int OFS_W       = 8,
   parameter int CNT_W       = 10,
   parameter int BURST_START = 20,
   parameter int BURST_LEN   = 36,
   localparam int NH     = WORD_W / HALF_W,
   localparam int ADDR_W = ((NH > 1) ? $clog2(NH) : 1) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              pix_tick,
   input  logic              line_start,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [HALF_W-1:0] wr_data,
   input  logic [1:0]        std_sel,
   input  logic              custom_en,
   input  logic              secam_en,
   input  logic [OFS_W-1:0]  phase_ofs,
   output logic [PH_W-1:0]   phase_o,
   output logic              burst_o,
   output logic              v_invert_o
);

   if (OFS_W > PH_W) begin : g_bad_ofs
      $error("offset must fit inside the phase output");
   end

   tv_std_e           std_e;
   logic              line_odd;
   logic [WORD_W-1:0] fcw;

   assign std_e = tv_std_e'(std_sel);

   nco_fcw_bank #(.HALF_W(HALF_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .std_sel   (std_e),
      .custom_en (custom_en),
      .secam_en  (secam_en),
      .line_odd  (line_odd),
      .fcw_o     (fcw)
   );

   nco_phase_acc #(.PH_W(PH_W), .OFS_W(OFS_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .line_start (line_start),
      .pix_tick   (pix_tick),
      .phase_ofs  (phase_ofs),
      .fcw        (fcw),
      .phase_o    (phase_o)
   );

   nco_line_timing #(
      .CNT_W       (CNT_W),
      .BURST_START (BURST_START),
      .BURST_LEN   (BURST_LEN)
   ) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .line_start (line_start),
      .pix_tick   (pix_tick),
      .line_odd_o (line_odd),
      .burst_o    (burst_o)
   );

   assign v_invert_o = line_odd && (std_e != STD_NTSC) && !secam_en;

endmodule

// File: rtl/subcarrier_nco_chk.sv
module subcarrier_nco_chk #(
   parameter int PH_W  = 10,
   parameter int OFS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             pix_tick,
   input logic             line_start,
   input logic [OFS_W-1:0] phase_ofs,
   input logic [PH_W-1:0]  phase_o,
   input logic             burst_o,
   input logic             line_odd
);

   AST_RESEED_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !soft_rst) |=> ##1
         (phase_o == (PH_W'($past(phase_ofs, 2)) << (PH_W - OFS_W)))); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_tick && !line_start && !soft_rst) |=> ##1 $stable(phase_o)); // R3

   AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> ##1 (phase_o == '0)); // R10

   AST_PARITY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !soft_rst) |=> (line_odd != $past(line_odd))); // R8

   AST_BURST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_o) |-> $past(pix_tick && !line_start && !soft_rst)); // R9

endmodule

bind subcarrier_nco subcarrier_nco_chk #(.PH_W(PH_W), .OFS_W(OFS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_rst   (soft_rst),
   .pix_tick   (pix_tick),
   .line_start (line_start),
   .phase_ofs  (phase_ofs),
   .phase_o    (phase_o),
   .burst_o    (burst_o),
   .line_odd   (line_odd)
);

// File: tb/subcarrier_nco_test.sv
module subcarrier_nco_test;

   localparam int BS = 20;
   localparam int BE = 56;
   localparam logic [31:0] W_STD [4] = '{32'h21F07C1F, 32'h2A098ACB, 32'h21E6EFE3, 32'h21F69446};
   localparam logic [31:0] W_MAIN = 32'h29C71C72;
   localparam logic [31:0] W_ALT  = 32'h284BDA13;

   logic        clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, pix_tick = 1'b0, line_start = 1'b0;
   logic        wr_en = 1'b0, custom_en = 1'b0, secam_en = 1'b0;
   logic [1:0]  wr_addr = '0, std_sel = '0;
   logic [15:0] wr_data = '0;
   logic [7:0]  phase_ofs = '0;
   logic [9:0]  phase_o;
   logic        burst_o, v_invert_o;

   always #5 clk = ~clk;

   subcarrier_nco uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pix_tick(pix_tick),
      .line_start(line_start), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .std_sel(std_sel), .custom_en(custom_en), .secam_en(secam_en),
      .phase_ofs(phase_ofs), .phase_o(phase_o), .burst_o(burst_o), .v_invert_o(v_invert_o)
   );

   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;
   string       req = "R1";
   logic [30:0] m_acc;
   logic [31:0] m_main, m_alt;
   logic        m_odd;
   int          m_cnt;
   logic [9:0]  m_ph;

   task automatic check(string r, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", r, act, exp);
      end
   endtask

   task automatic model_clear();
      m_acc = '0; m_main = W_MAIN; m_alt = W_ALT; m_odd = 1'b0; m_cnt = 0;
   endtask

   function automatic logic [31:0] eff_word();
      if (secam_en)  return m_odd ? m_alt : m_main;
      if (custom_en) return m_main;
      return W_STD[std_sel];
   endfunction

   task automatic step();
      logic [31:0] w;
      @(posedge clk);
      w = eff_word();
      m_ph = m_acc[30:21];
      if (soft_rst) model_clear();
      else begin
         if (wr_en) begin
            case (wr_addr)
               2'd0: m_main[31:16] = wr_data;
               2'd1: m_main[15:0]  = wr_data;
               2'd2: m_alt[31:16]  = wr_data;
               default: m_alt[15:0] = wr_data;
            endcase
         end
         if (line_start) begin
            m_acc = {phase_ofs, 23'd0}; m_odd = ~m_odd; m_cnt = 0;
         end else if (pix_tick) begin
            m_acc = m_acc + w[30:0];
            if (m_cnt < 1023) m_cnt++;
         end
      end
      #1;
      check(req, 32'(phase_o), 32'(m_ph));
      check(req, 32'(burst_o), 32'(m_cnt >= BS && m_cnt < BE));
      check(req, 32'(v_invert_o), 32'(m_odd && std_sel != 2'd0 && !secam_en));
   endtask

   task automatic run_line(int n);
      line_start = 1'b1; pix_tick = 1'b1;   // tick in the same cycle: reseed must win (R4)
      step();
      line_start = 1'b0;
      repeat (n) step();
      pix_tick = 1'b0;
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      model_clear();
      m_ph = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", 32'(phase_o), 0);
      check("R1", 32'(burst_o), 0);
      check("R1", 32'(v_invert_o), 0);
      rst_n = 1'b1;

      req = "R5";
      for (int s = 0; s < 4; s++) begin
         std_sel = 2'(s);
         run_line(60);
      end
      req = "R9";
      std_sel = 2'd0;
      run_line(BE + 4);

      req = "R3";
      repeat (10) step();

      req = "R8";
      std_sel = 2'd1;
      repeat (4) run_line(3);
      std_sel = 2'd0;
      repeat (2) run_line(3);

      req = "R6";
      wr(2'd0, 16'h1234);
      wr(2'd1, 16'h5678);
      custom_en = 1'b1;
      run_line(30);
      custom_en = 1'b0;
      run_line(10);

      req = "R2";
      wr(2'd0, 16'h8000);
      wr(2'd1, 16'h0000);
      custom_en = 1'b1;
      phase_ofs = 8'h28;
      run_line(8);
      wr(2'd0, 16'h4000);
      run_line(8);
      custom_en = 1'b0;

      req = "R7";
      wr(2'd0, 16'h1234);
      wr(2'd1, 16'h5678);
      secam_en = 1'b1;
      repeat (2) run_line(25);
      wr(2'd2, 16'h0300);
      wr(2'd3, 16'h0001);
      repeat (2) run_line(12);
      custom_en = 1'b1;
      repeat (2) run_line(10);
      custom_en = 1'b0;
      secam_en = 1'b0;

      req = "R4";
      for (int o = 0; o < 256; o++) begin
         phase_ofs = 8'(o);
         std_sel = 2'(o % 4);
         run_line(2);
      end

      req = "R10";
      secam_en = 1'b1;
      soft_rst = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'hFFFF;
      line_start = 1'b1; pix_tick = 1'b1;
      step();
      soft_rst = 1'b0; wr_en = 1'b0; line_start = 1'b0;
      repeat (3) step();
      pix_tick = 1'b0;
      repeat (2) run_line(15);
      secam_en = 1'b0;

      finish_run();
   end

endmodule